// File: doc/BRIEF.md
# Tick-Sampled Integrate-and-Fire Neuron

This block is one digital neuron that counts incoming spike events and decides whether to fire only when a coarse wallclock tick arrives. An input spike is a one-cycle strobe that carries no payload; only its presence and its cycle matter. Each such strobe adds one to an internal level register, which stops at its maximum value rather than wrapping.

A tick strobe compares the stored level against a programmable threshold. If the level is below the threshold, the tick has no effect. If the level has reached the threshold, the level is cleared and the block raises a one-cycle output spike in the cycle after the tick. The threshold can be written only in a cycle with no spike and no tick, so a comparison never sees a threshold that changes under it.

Top module: `tick_neuron`

## Requirements
- R1: After reset the output spike is low, the stored level is 0 and the threshold holds the parameter RST_THR (default 4).
- R2: A cycle with spike_in_vld high and tick_stb low raises the stored level by exactly one.
- R3: The stored level saturates at 2^W-1 (65535 by default). Further spikes leave it at that value.
- R4: A tick with the stored level below the threshold leaves the level unchanged and produces no output spike.
- R5: A tick with the stored level at or above the threshold clears the level and raises spike_out_vld for exactly one cycle. This includes a threshold of 0, where every tick fires.
- R6: When a spike and a tick arrive in the same cycle, the tick is judged on the level held before that cycle. The spike is then added to the result, so the level becomes 1 after a firing tick and the old level plus one otherwise.
- R7: A threshold write (thr_wr_en high) takes effect only in a cycle where spike_in_vld and tick_stb are both low. A write in any other cycle is ignored.
- R8: spike_out_vld is high only in the cycle directly after a cycle with tick_stb high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| spike_in_vld | input | 1 | One incoming spike event per high cycle |
| tick_stb | input | 1 | Wallclock tick; triggers the threshold check |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_data | input | W | New threshold value |
| spike_out_vld | output | 1 | One-cycle pulse for an emitted spike |

## Verification
The assertions treat every high cycle of spike_in_vld and tick_stb as a separate event. They place no limit on how closely ticks follow one another, so back-to-back firing with a zero threshold stays legal. The checks on level growth and stillness apply only in cycles where the tick is low. The bench drives each input cycle by cycle at the falling edge, so every spike and tick lasts exactly one cycle. It observes the hidden level only by the way later ticks fire, using chosen thresholds and spike counts that tell a saturated level from a wrapped one and a lost same-cycle spike from a counted one.

// File: rtl/tick_neuron_pkg.sv
package tick_neuron_pkg;

  // Next-state action on the stored integrand
  typedef enum logic [1:0] {
    ACT_HOLD      = 2'd0,
    ACT_INC       = 2'd1,
    ACT_CLEAR     = 2'd2,
    ACT_CLEAR_INC = 2'd3
  } integ_act_e;

endpackage

// File: rtl/neuron_thr_reg.sv
module neuron_thr_reg #(
  parameter int W       = 16,
  parameter int RST_THR = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         busy,
  output logic [W-1:0] thr_q
);

  localparam logic [W-1:0] THR_INIT = W'(RST_THR);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= THR_INIT;
    end else if (wr_en && !busy) begin
      thr_q <= wr_data;
    end
  end

endmodule

// File: rtl/neuron_fire_eval.sv
module neuron_fire_eval
  import tick_neuron_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] integ_q,
  input  logic [W-1:0] thr_q,
  input  logic         tick,
  input  logic         spike,
  output logic         fire,
  output integ_act_e   act
);

  logic reached;

  always_comb begin
    reached = (integ_q >= thr_q);
    fire    = tick && reached;
    // The tick is judged first; a same-cycle spike lands afterwards.
    unique case ({fire, spike})
      2'b11:   act = ACT_CLEAR_INC;
      2'b10:   act = ACT_CLEAR;
      2'b01:   act = ACT_INC;
      default: act = ACT_HOLD;
    endcase
  end

endmodule

// File: rtl/neuron_integ_acc.sv
module neuron_integ_acc
  import tick_neuron_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  integ_act_e   act,
  output logic [W-1:0] integ_q
);

  localparam logic [W-1:0] LVL_MAX = {W{1'b1}};
  localparam logic [W-1:0] LVL_ONE = W'(1);

  logic [W-1:0] inc_val;

  always_comb begin
    inc_val = (integ_q == LVL_MAX) ? LVL_MAX : (integ_q + LVL_ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q <= '0;
    end else begin
      unique case (act)
        ACT_INC:       integ_q <= inc_val;
        ACT_CLEAR:     integ_q <= '0;
        ACT_CLEAR_INC: integ_q <= LVL_ONE;
        default:       integ_q <= integ_q;
      endcase
    end
  end

endmodule

// File: rtl/neuron_spike_out.sv
module neuron_spike_out (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic spike_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      spike_q <= 1'b0;
    end else begin
      spike_q <= fire;
    end
  end

endmodule

// File: rtl/tick_neuron.sv
module tick_neuron
  import tick_neuron_pkg::*;
#(
  parameter int W       = 16,
  parameter int RST_THR = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         spike_in_vld,
  input  logic         tick_stb,
  input  logic         thr_wr_en,
  input  logic [W-1:0] thr_wr_data,
  output logic         spike_out_vld
);

  logic [W-1:0] thr_q;
  logic [W-1:0] integ_q;
  logic         fire;
  logic         busy;
  integ_act_e   act;

  assign busy = spike_in_vld || tick_stb;

  neuron_thr_reg #(.W(W), .RST_THR(RST_THR)) u_thr (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (thr_wr_en),
    .wr_data (thr_wr_data),
    .busy    (busy),
    .thr_q   (thr_q)
  );

  neuron_fire_eval #(.W(W)) u_eval (
    .integ_q (integ_q),
    .thr_q   (thr_q),
    .tick    (tick_stb),
    .spike   (spike_in_vld),
    .fire    (fire),
    .act     (act)
  );

  neuron_integ_acc #(.W(W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .act     (act),
    .integ_q (integ_q)
  );

  neuron_spike_out u_out (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire),
    .spike_q (spike_out_vld)
  );

endmodule

// File: rtl/tick_neuron_chk.sv
module tick_neuron_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         spike_in_vld,
  input logic         tick_stb,
  input logic         spike_out_vld,
  input logic [W-1:0] integ_q,
  input logic [W-1:0] thr_q
);

  localparam logic [W-1:0] LVL_MAX = {W{1'b1}};

  // R2
  spike_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (spike_in_vld && !tick_stb && integ_q != LVL_MAX) |=> (integ_q == $past(integ_q) + W'(1)));

  // R3
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (spike_in_vld && !tick_stb && integ_q == LVL_MAX) |=> (integ_q == LVL_MAX));

  // R4
  below_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_stb && !spike_in_vld && integ_q < thr_q) |=> (!spike_out_vld && $stable(integ_q)));

  // R5
  fire_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_stb && !spike_in_vld && integ_q >= thr_q) |=> (spike_out_vld && integ_q == '0));

  // R6
  same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_stb && spike_in_vld && integ_q >= thr_q) |=> (spike_out_vld && integ_q == W'(1)));

  // R7
  thr_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (spike_in_vld || tick_stb) |=> $stable(thr_q));

  // R8
  out_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    spike_out_vld |-> $past(tick_stb));

endmodule

bind tick_neuron tick_neuron_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .spike_in_vld  (spike_in_vld),
  .tick_stb      (tick_stb),
  .spike_out_vld (spike_out_vld),
  .integ_q       (integ_q),
  .thr_q         (thr_q)
);

// File: tb/tick_neuron_bench.sv
module tick_neuron_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         spike_in_vld = 1'b0;
  logic         tick_stb = 1'b0;
  logic         thr_wr_en = 1'b0;
  logic [W-1:0] thr_wr_data = '0;
  logic         spike_out_vld;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_neuron #(.W(W), .RST_THR(4)) u_tick_neuron (
    .clk           (clk),
    .rst           (rst),
    .spike_in_vld  (spike_in_vld),
    .tick_stb      (tick_stb),
    .thr_wr_en     (thr_wr_en),
    .thr_wr_data   (thr_wr_data),
    .spike_out_vld (spike_out_vld)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: spike_out_vld=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle of stimulus; returns the output sampled just after the edge.
  task automatic step(input logic spk, input logic tk, input logic we,
                      input logic [W-1:0] wd, output logic out);
    @(negedge clk);
    spike_in_vld = spk;
    tick_stb     = tk;
    thr_wr_en    = we;
    thr_wr_data  = wd;
    @(posedge clk);
    #1;
    out = spike_out_vld;
    @(negedge clk);
    spike_in_vld = 1'b0;
    tick_stb     = 1'b0;
    thr_wr_en    = 1'b0;
  endtask

  task automatic spikes(input int n);
    logic o;
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, '0, o);
  endtask

  task automatic set_thr(input logic [W-1:0] v);
    logic o;
    step(1'b0, 1'b0, 1'b1, v, o);
  endtask

  task automatic tick_expect(input string req, input logic exp);
    logic o;
    step(1'b0, 1'b1, 1'b0, '0, o);
    check(req, o, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 output low in reset", spike_out_vld, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 output low after reset", spike_out_vld, 1'b0);
    tick_expect("R1 level 0 below default 4", 1'b0);
    spikes(3);
    tick_expect("R4 level 3 below default threshold 4", 1'b0);
    spikes(1);
    tick_expect("R2 R4 level kept, 4 reaches threshold", 1'b1);
    tick_expect("R5 level cleared after firing", 1'b0);
  endtask

  task automatic t_pulse;
    logic o;
    int   cnt = 0;
    set_thr(W'(2));
    spikes(2);
    tick_expect("R5 fires at threshold", 1'b1);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0, 1'b0, '0, o);
      if (o) cnt++;
    end
    check("R5 R8 single-cycle pulse, none without tick", cnt != 0, 1'b0);
    spikes(5);
    tick_expect("R5 above threshold fires", 1'b1);
  endtask

  task automatic t_same_cycle;
    logic o;
    set_thr(W'(3));
    spikes(3);
    step(1'b1, 1'b1, 1'b0, '0, o);
    check("R6 tick judged on old level 3", o, 1'b1);
    spikes(2);
    tick_expect("R6 same-cycle spike counted after clear", 1'b1);
    spikes(1);
    step(1'b1, 1'b1, 1'b0, '0, o);
    check("R6 old level 1 below 3, no fire", o, 1'b0);
    spikes(1);
    tick_expect("R6 level 1+1+1 reaches 3", 1'b1);
  endtask

  task automatic t_thr_write;
    logic o;
    set_thr(W'(2));
    step(1'b1, 1'b0, 1'b1, W'(10), o);
    spikes(1);
    tick_expect("R7 write during spike ignored", 1'b1);
    step(1'b0, 1'b1, 1'b1, W'(10), o);
    check("R7 tick at level 0 below 2", o, 1'b0);
    spikes(2);
    tick_expect("R7 write during tick ignored", 1'b1);
    set_thr(W'(6));
    spikes(5);
    tick_expect("R7 idle write to 6 takes effect", 1'b0);
  endtask

  task automatic t_thr_zero;
    set_thr(W'(0));
    tick_expect("R5 threshold 0 fires (pending level)", 1'b1);
    tick_expect("R5 threshold 0 fires at level 0", 1'b1);
    tick_expect("R5 threshold 0 fires again", 1'b1);
  endtask

  task automatic t_saturate;
    logic o;
    int   cnt = 0;
    set_thr({W{1'b1}});
    for (int i = 0; i < (1 << W) + 1; i++) begin
      step(1'b1, 1'b0, 1'b0, '0, o);
      if (o) cnt++;
    end
    check("R8 no output during spikes without tick", cnt != 0, 1'b0);
    tick_expect("R3 level saturated at max reaches max threshold", 1'b1);
    tick_expect("R5 cleared after saturated fire", 1'b0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_pulse();
    t_same_cycle();
    t_thr_write();
    t_thr_zero();
    t_saturate();
    finish_run();
  end

endmodule